// File: doc/BRIEF.md
# Warp-Synchronized SIMT Register File

This block holds the operand storage of one small group of threads that run in lock step. Software sees one flat 8-bit register index. The lower half of the index space is private to each thread. The upper half is shared by the whole group: a bank of group registers, a bank of immediate registers that pairs one-to-one with the group registers, and a bank of read-only constants.

A pass walks the threads of the group one at a time, in ascending thread number. While a pass runs, three source ports read on behalf of the thread the pass is currently visiting. One writeback port per cycle carries an explicit thread number.

A writeback to a group or immediate register takes effect only when it comes from the configured reference thread. Because that storage is shared, every thread of the group then reads the same value. Writebacks from other threads to the shared range are dropped without any flag. Constants can be written only through a separate load port, and only while the group is idle. A writeback aimed at the constant range is refused and raises a one-cycle illegal-write pulse.

Top module: `simt_group_regfile`

## Requirements
- R1: Indices 0..127 (bit 7 = 0) select one of 128 thread-private registers of the thread being read or written. Indices 128..159 (bits 7:5 = 100) select group register index[4:0]. Indices 160..191 (bits 7:5 = 101) select immediate register index[4:0]. Indices 192..255 (bits 7:6 = 11) select constant index[5:0].
- R2: The three read ports are independent, and each one may address any range. When `rd_en_i` is high at a clock edge, each output shows the addressed register of thread `cur_tid_o` after that edge. When `rd_en_i` is low, the outputs hold their value.
- R3: The immediate bank is separate storage from the group bank. Immediate register k and group register k hold different values, and both are shared by all threads.
- R4: A writeback to indices 192..255 leaves every constant unchanged. It raises `illegal_wr_o` for exactly the one cycle after the write.
- R5: A writeback to a thread-private register changes that register of thread `wr_tid_i` only.
- R6: A writeback to the group or immediate range from thread `ref_tid_i` is seen by every thread of the group.
- R7: A pulse on `pass_start_i` while `pass_busy_o` is low starts a pass. During the pass, `pass_busy_o` is high and `cur_tid_o` steps 0, 1, … NUM_THREADS-1, one step per cycle. The pass then ends with `cur_tid_o` back at 0. A start pulse during a pass is ignored.
- R8: A writeback to the group or immediate range from any thread other than `ref_tid_i` is discarded and raises no flag.
- R9: A constant is written through `cfg_we_i`/`cfg_idx_i` (constant index 0..63, that is, register 192 + `cfg_idx_i`). The write is accepted only when `pass_busy_o` is low and `wr_en_i` is low; otherwise it is ignored.
- R10: A read in the same cycle as a write to the same register returns the old value. The new value is returned from the next cycle on.
- R11: After reset, all storage and all outputs are zero, and the group is idle with `cur_tid_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_start_i | input | 1 | Start a pass over the threads |
| pass_busy_o | output | 1 | A pass is in progress |
| cur_tid_o | output | TID_W | Thread the read ports serve |
| ref_tid_i | input | TID_W | Thread whose shared-range writebacks commit |
| rd_en_i | input | 1 | Capture new read data |
| rd_idx0_i | input | 8 | Source index, port 0 |
| rd_idx1_i | input | 8 | Source index, port 1 |
| rd_idx2_i | input | 8 | Source index, port 2 |
| rd_data0_o | output | DATA_W | Read data, port 0 |
| rd_data1_o | output | DATA_W | Read data, port 1 |
| rd_data2_o | output | DATA_W | Read data, port 2 |
| wr_en_i | input | 1 | Writeback valid |
| wr_tid_i | input | TID_W | Thread issuing the writeback |
| wr_idx_i | input | 8 | Writeback index |
| wr_data_i | input | DATA_W | Writeback data |
| illegal_wr_o | output | 1 | Pulse after a writeback to the constant range |
| cfg_we_i | input | 1 | Constant load strobe |
| cfg_idx_i | input | 6 | Constant index |
| cfg_data_i | input | DATA_W | Constant value |

## Verification
The bench builds the block with four threads and 32-bit data. A full pass is therefore four visits, and the pass order, the wrap of the cursor and the end of the pass are all observed at the ports. Four threads also leave room for one reference thread and several non-reference threads, so dropped shared writes can be told apart from committed ones. Switching the reference thread partway through the bench shows that shared values survive the change.

// File: rtl/simt_rf_pkg.sv
package simt_rf_pkg;

    localparam int IDX_W       = 8;
    localparam int THREAD_REGS = 128;
    localparam int WARP_REGS   = 32;
    localparam int CONST_REGS  = 64;
    localparam int TREG_W      = $clog2(THREAD_REGS);
    localparam int WREG_W      = $clog2(WARP_REGS);
    localparam int CREG_W      = $clog2(CONST_REGS);
    localparam int RD_PORTS    = 3;

    typedef enum logic [1:0] {
        RGN_THREAD = 2'd0,
        RGN_WARP   = 2'd1,
        RGN_IMM    = 2'd2,
        RGN_CONST  = 2'd3
    } rgn_e;

    function automatic rgn_e idx_region(input logic [IDX_W-1:0] idx);
        if (!idx[7])     return RGN_THREAD;
        else if (idx[6]) return RGN_CONST;
        else if (idx[5]) return RGN_IMM;
        else             return RGN_WARP;
    endfunction

endpackage

// File: rtl/simt_rf_pass_seq.sv
module simt_rf_pass_seq #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic [TID_W-1:0] cur_o
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);

    typedef struct packed {
        logic             busy;
        logic [TID_W-1:0] cur;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start_i) begin
                seq_d.busy = 1'b1;
                seq_d.cur  = '0;
            end
        end else if (seq_q.cur == LAST_TID) begin
            seq_d.busy = 1'b0;
            seq_d.cur  = '0;
        end else begin
            seq_d.cur = seq_q.cur + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy_o = seq_q.busy;
    assign cur_o  = seq_q.cur;

    // R7
    seq_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_q.busy && start_i) |=> (seq_q.busy && seq_q.cur == '0));

    // R7
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cur != LAST_TID) |=>
            (seq_q.busy && seq_q.cur == TID_W'($past(seq_q.cur) + 1'b1)));

    // R7
    seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && seq_q.cur == LAST_TID) |=> (!seq_q.busy && seq_q.cur == '0));

endmodule

// File: rtl/simt_rf_thread_bank.sv
module simt_rf_thread_bank
    import simt_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [TREG_W-1:0]                widx_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic [RD_PORTS-1:0][TREG_W-1:0]  ridx_i,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rdata_o
);

    logic [THREAD_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we_i) regs_d[widx_i] = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata_o[p] = regs_q[ridx_i[p]];
    end

    // R5
    tbank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(regs_q));

    // R5
    tbank_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (regs_q[$past(widx_i)] == $past(wdata_i)));

endmodule

// File: rtl/simt_rf_shared_bank.sv
module simt_rf_shared_bank
    import simt_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             warp_we_i,
    input  logic                             imm_we_i,
    input  logic [WREG_W-1:0]                widx_i,
    input  logic [DATA_W-1:0]                wdata_i,
    input  logic                             cfg_we_i,
    input  logic [CREG_W-1:0]                cfg_idx_i,
    input  logic [DATA_W-1:0]                cfg_data_i,
    input  logic [RD_PORTS-1:0][IDX_W-1:0]   ridx_i,
    output logic [RD_PORTS-1:0][DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [WARP_REGS-1:0][DATA_W-1:0]  warp;
        logic [WARP_REGS-1:0][DATA_W-1:0]  imm;
        logic [CONST_REGS-1:0][DATA_W-1:0] cnst;
    } shr_t;

    shr_t shr_d, shr_q;

    always_comb begin
        shr_d = shr_q;
        if (warp_we_i) shr_d.warp[widx_i]   = wdata_i;
        if (imm_we_i)  shr_d.imm[widx_i]    = wdata_i;
        if (cfg_we_i)  shr_d.cnst[cfg_idx_i] = cfg_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shr_q <= '0;
        else        shr_q <= shr_d;
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        always_comb begin
            unique case (idx_region(ridx_i[p]))
                RGN_WARP:  rdata_o[p] = shr_q.warp[ridx_i[p][WREG_W-1:0]];
                RGN_IMM:   rdata_o[p] = shr_q.imm[ridx_i[p][WREG_W-1:0]];
                RGN_CONST: rdata_o[p] = shr_q.cnst[ridx_i[p][CREG_W-1:0]];
                default:   rdata_o[p] = '0;
            endcase
        end
    end

    // R8
    warp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !warp_we_i |=> $stable(shr_q.warp));

    // R3
    imm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !imm_we_i |=> $stable(shr_q.imm));

    // R9
    const_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(shr_q.cnst));

endmodule

// File: rtl/simt_group_regfile.sv
module simt_group_regfile
    import simt_rf_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int DATA_W      = 32,
    parameter int TID_W       = $clog2(NUM_THREADS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_start_i,
    output logic              pass_busy_o,
    output logic [TID_W-1:0]  cur_tid_o,
    input  logic [TID_W-1:0]  ref_tid_i,
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx0_i,
    input  logic [IDX_W-1:0]  rd_idx1_i,
    input  logic [IDX_W-1:0]  rd_idx2_i,
    output logic [DATA_W-1:0] rd_data0_o,
    output logic [DATA_W-1:0] rd_data1_o,
    output logic [DATA_W-1:0] rd_data2_o,
    input  logic              wr_en_i,
    input  logic [TID_W-1:0]  wr_tid_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              illegal_wr_o,
    input  logic              cfg_we_i,
    input  logic [CREG_W-1:0] cfg_idx_i,
    input  logic [DATA_W-1:0] cfg_data_i
);

    typedef struct packed {
        logic [RD_PORTS-1:0][DATA_W-1:0] rd;
        logic                            illegal;
    } out_t;

    out_t out_d, out_q;

    logic [RD_PORTS-1:0][IDX_W-1:0]  ridx;
    logic [RD_PORTS-1:0][TREG_W-1:0] ridx_thr;
    logic [RD_PORTS-1:0][DATA_W-1:0] shr_rd;
    logic [RD_PORTS-1:0][DATA_W-1:0] thr_rd [NUM_THREADS];
    logic [RD_PORTS-1:0][DATA_W-1:0] sel_rd;
    logic [NUM_THREADS-1:0]          thr_we;

    rgn_e wr_rgn;
    logic from_ref, warp_we, imm_we, cfg_ok;

    assign ridx = {rd_idx2_i, rd_idx1_i, rd_idx0_i};

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_ridx
        assign ridx_thr[p] = ridx[p][TREG_W-1:0];
    end

    // writeback steering
    assign wr_rgn   = idx_region(wr_idx_i);
    assign from_ref = (wr_tid_i == ref_tid_i);
    assign warp_we  = wr_en_i && from_ref && (wr_rgn == RGN_WARP);
    assign imm_we   = wr_en_i && from_ref && (wr_rgn == RGN_IMM);
    assign cfg_ok   = cfg_we_i && !pass_busy_o && !wr_en_i;

    simt_rf_pass_seq #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pass_start_i),
        .busy_o  (pass_busy_o),
        .cur_o   (cur_tid_o)
    );

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign thr_we[t] = wr_en_i && (wr_rgn == RGN_THREAD) && (wr_tid_i == TID_W'(t));

        simt_rf_thread_bank #(
            .DATA_W (DATA_W)
        ) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (thr_we[t]),
            .widx_i  (wr_idx_i[TREG_W-1:0]),
            .wdata_i (wr_data_i),
            .ridx_i  (ridx_thr),
            .rdata_o (thr_rd[t])
        );
    end

    simt_rf_shared_bank #(
        .DATA_W (DATA_W)
    ) shared_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .warp_we_i  (warp_we),
        .imm_we_i   (imm_we),
        .widx_i     (wr_idx_i[WREG_W-1:0]),
        .wdata_i    (wr_data_i),
        .cfg_we_i   (cfg_ok),
        .cfg_idx_i  (cfg_idx_i),
        .cfg_data_i (cfg_data_i),
        .ridx_i     (ridx),
        .rdata_o    (shr_rd)
    );

    // pick the visited thread, then the region per port
    always_comb begin
        sel_rd = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (cur_tid_o == TID_W'(t)) sel_rd = thr_rd[t];
        end
    end

    always_comb begin
        out_d = out_q;
        if (rd_en_i) begin
            for (int p = 0; p < RD_PORTS; p++) begin
                out_d.rd[p] = (idx_region(ridx[p]) == RGN_THREAD) ? sel_rd[p] : shr_rd[p];
            end
        end
        out_d.illegal = wr_en_i && (wr_rgn == RGN_CONST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data0_o   = out_q.rd[0];
    assign rd_data1_o   = out_q.rd[1];
    assign rd_data2_o   = out_q.rd[2];
    assign illegal_wr_o = out_q.illegal;

    // R4
    illegal_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i[7:6] == 2'b11) |=> illegal_wr_o);

    // R4
    illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i || wr_idx_i[7:6] != 2'b11) |=> !illegal_wr_o);

    // R8
    nonref_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_idx_i[7:6] == 2'b10 && wr_tid_i != ref_tid_i) |=> !illegal_wr_o);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> ($stable(rd_data0_o) && $stable(rd_data1_o) && $stable(rd_data2_o)));

    // R9
    cfg_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_busy_o |-> !cfg_ok);

endmodule

// File: tb/simt_group_regfile_tb_top.sv
module simt_group_regfile_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 4;
    localparam int DW         = 32;
    localparam int TW         = 2;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pass_start = 1'b0;
    logic          pass_busy;
    logic [TW-1:0] cur_tid;
    logic [TW-1:0] ref_tid = '0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_idx0 = '0, rd_idx1 = '0, rd_idx2 = '0;
    logic [DW-1:0] rd_data0, rd_data1, rd_data2;
    logic          wr_en = 1'b0;
    logic [TW-1:0] wr_tid = '0;
    logic [7:0]    wr_idx = '0;
    logic [DW-1:0] wr_data = '0;
    logic          illegal_wr;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_idx = '0;
    logic [DW-1:0] cfg_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [DW-1:0] got0 [NT];
    logic [DW-1:0] got1 [NT];
    logic [DW-1:0] got2 [NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    simt_group_regfile #(
        .NUM_THREADS (NT),
        .DATA_W      (DW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .pass_start_i (pass_start),
        .pass_busy_o  (pass_busy),
        .cur_tid_o    (cur_tid),
        .ref_tid_i    (ref_tid),
        .rd_en_i      (rd_en),
        .rd_idx0_i    (rd_idx0),
        .rd_idx1_i    (rd_idx1),
        .rd_idx2_i    (rd_idx2),
        .rd_data0_o   (rd_data0),
        .rd_data1_o   (rd_data1),
        .rd_data2_o   (rd_data2),
        .wr_en_i      (wr_en),
        .wr_tid_i     (wr_tid),
        .wr_idx_i     (wr_idx),
        .wr_data_i    (wr_data),
        .illegal_wr_o (illegal_wr),
        .cfg_we_i     (cfg_we),
        .cfg_idx_i    (cfg_idx),
        .cfg_data_i   (cfg_data)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_write(input logic [TW-1:0] tid, input logic [7:0] idx,
                            input logic [DW-1:0] data);
        wr_en = 1'b1; wr_tid = tid; wr_idx = idx; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_cfg(input logic [5:0] idx, input logic [DW-1:0] data);
        cfg_we = 1'b1; cfg_idx = idx; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one full pass; also checks the visiting order (R7)
    task automatic run_pass(input logic [7:0] i0, input logic [7:0] i1, input logic [7:0] i2);
        rd_idx0 = i0; rd_idx1 = i1; rd_idx2 = i2;
        rd_en = 1'b1; pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        for (int t = 0; t < NT; t++) begin
            chk("R7", "cursor order", DW'(cur_tid), DW'(t));
            chk("R7", "busy in pass", DW'(pass_busy), 1);
            @(negedge clk);
            got0[t] = rd_data0; got1[t] = rd_data1; got2[t] = rd_data2;
        end
        chk("R7", "idle after pass", DW'(pass_busy), 0);
        chk("R7", "cursor back to 0", DW'(cur_tid), 0);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11", "reset rd0", rd_data0, '0);
        chk("R11", "reset rd2", rd_data2, '0);
        chk("R11", "reset illegal", DW'(illegal_wr), 0);
        chk("R11", "reset busy", DW'(pass_busy), 0);
        chk("R11", "reset cursor", DW'(cur_tid), 0);
        run_pass(8'd9, 8'd140, 8'd250);
        for (int t = 0; t < NT; t++) begin
            chk("R11", "thread reg zero", got0[t], '0);
            chk("R11", "warp reg zero", got1[t], '0);
            chk("R11", "const zero", got2[t], '0);
        end
    endtask

    task automatic t_private();
        for (int t = 0; t < NT; t++) do_write(TW'(t), 8'd5, DW'(32'h100 + t));
        do_write(2'd1, 8'd127, 32'hABCD);
        run_pass(8'd5, 8'd127, 8'd0);
        for (int t = 0; t < NT; t++) begin
            chk("R5", "private reg 5", got0[t], DW'(32'h100 + t));
            chk("R1", "private reg 127", got1[t], (t == 1) ? 32'hABCD : 32'h0);
            chk("R5", "untouched reg 0", got2[t], '0);
        end
    endtask

    task automatic t_warp();
        ref_tid = 2'd2;
        do_write(2'd0, 8'd130, 32'hA1);
        chk("R8", "no flag on dropped write", DW'(illegal_wr), 0);
        do_write(2'd2, 8'd130, 32'hB2);
        do_write(2'd3, 8'd130, 32'hC3);
        chk("R8", "no flag on dropped write", DW'(illegal_wr), 0);
        run_pass(8'd130, 8'd2, 8'd131);
        for (int t = 0; t < NT; t++) begin
            chk("R6", "ref value broadcast", got0[t], 32'hB2);
            chk("R1", "warp index 2 not thread reg 2", got1[t], '0);
            chk("R8", "neighbour warp reg untouched", got2[t], '0);
        end
    endtask

    task automatic t_indirect();
        ref_tid = 2'd1;
        do_write(2'd1, 8'd165, 32'h5A5A);
        do_write(2'd1, 8'd133, 32'h33);
        do_write(2'd0, 8'd165, 32'hFFFF);
        run_pass(8'd165, 8'd133, 8'd130);
        for (int t = 0; t < NT; t++) begin
            chk("R3", "imm reg 5", got0[t], 32'h5A5A);
            chk("R3", "warp reg 5 distinct", got1[t], 32'h33);
            chk("R6", "value kept after ref change", got2[t], 32'hB2);
        end
    endtask

    task automatic t_const();
        do_cfg(6'd3, 32'hC0DE);
        // load while a writeback is active: ignored
        wr_en = 1'b1; wr_tid = 2'd0; wr_idx = 8'd20; wr_data = 32'h1;
        cfg_we = 1'b1; cfg_idx = 6'd4; cfg_data = 32'hBAD4;
        @(negedge clk);
        wr_en = 1'b0; cfg_we = 1'b0;
        // writeback into constant range
        do_write(ref_tid, 8'd195, 32'hDEAD);
        chk("R4", "illegal pulse", DW'(illegal_wr), 1);
        @(negedge clk);
        chk("R4", "illegal one cycle", DW'(illegal_wr), 0);
        run_pass(8'd195, 8'd196, 8'd255);
        for (int t = 0; t < NT; t++) begin
            chk("R4", "const unchanged by writeback", got0[t], 32'hC0DE);
            chk("R9", "load with wr_en ignored", got1[t], '0);
            chk("R1", "top const", got2[t], '0);
        end
        // load during a pass: ignored
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        do_cfg(6'd10, 32'd77);
        repeat (NT) @(negedge clk);
        chk("R7", "pass finished", DW'(pass_busy), 0);
        run_pass(8'd202, 8'd195, 8'd0);
        chk("R9", "load during pass ignored", got0[0], '0);
        chk("R9", "const load visible", got1[3], 32'hC0DE);
    endtask

    task automatic t_same_cycle();
        // idle cursor is thread 0
        wr_en = 1'b1; wr_tid = 2'd0; wr_idx = 8'd5; wr_data = 32'h999;
        rd_en = 1'b1; rd_idx0 = 8'd5; rd_idx1 = 8'd195; rd_idx2 = 8'd133;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R10", "old value same cycle", rd_data0, 32'h100);
        chk("R2", "const port", rd_data1, 32'hC0DE);
        chk("R2", "warp port", rd_data2, 32'h33);
        @(negedge clk);
        chk("R10", "new value next cycle", rd_data0, 32'h999);
        rd_en = 1'b0; rd_idx0 = 8'd127;
        @(negedge clk);
        chk("R2", "hold with rd_en low", rd_data0, 32'h999);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_private();
        t_warp();
        t_indirect();
        t_const();
        t_same_cycle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule